// File: doc/BRIEF.md
# External Bus Hand-off Controller

This block decides when the chip gives its external memory port to an outside bus master. The outside master asks for the bus on an active-low request pin. The request is brought into the clock domain through a chain of flops. It is then weighed against the internal requesters: the core, and the DMA/peripheral path when it targets external space. The outside master has the lowest priority. It gets the bus only when no internal access is waiting, no internal transfer is still occupying the port, and the core is not between the two halves of a locked read pair.

The hand-over follows a fixed order. The controller first turns off every output driver enable of the port. One cycle later it asserts the active-low grant. When the outside master drops its request, the grant is removed first, and the driver enables come back one cycle after that. While the bus is away, any internal access to external space is stalled, and a held-off flag tells the system that an access is waiting on the outside master. When the bus returns, the stalled access goes ahead unchanged. An exclusive-mode input reserves the port for the core, so that DMA traffic no longer holds off an outside master. Outside requests are still granted in that mode.

Top module: `xbus_handoff`

## Requirements
- R1: The grant is never issued while a core request is pending. With `excl_mode` low, a pending DMA request also blocks the grant. With `core_req` held high, `xgnt_n` stays high for as long as it is held.
- R2: With the port idle, `xgnt_n` goes low on the 4th rising edge after `xreq_n` falls. It never goes low earlier than the 3rd rising edge.
- R3: While `xgnt_n` is low, every bit of `drv_en` is 0. The bits are: 0 address, 1 data, 2 memory selects, 3 boot select, 4 I/O select, 5 read strobe, 6 write strobe. While the core owns the port, all seven bits are 1.
- R4: A core or DMA access requested while the bus is away (or being handed over or back) sees its stall output (`core_stall` or `dma_stall`) at 1. It is accepted in the first cycle after the drivers come back on.
- R5: A core read accepted with `core_lock` high blocks the grant until the next core access has been accepted. An unlocked read followed by an idle port lets the grant through before the following write.
- R6: `xgnt_n` returns high on the 3rd rising edge after `xreq_n` rises. A stalled access is accepted on the 4th edge.
- R7: `drv_en` drops to 0 one cycle before `xgnt_n` falls. It returns to all ones one cycle after `xgnt_n` rises.
- R8: `held_off` is 1 exactly when `core_req` or `dma_req` is high while the controller is not in its owning state.
- R9: With `excl_mode` high, a continuously pending DMA request does not stop the grant. DMA is then accepted only when no grant is starting.
- R10: Each accepted access occupies the port for `XFER_CYC` cycles (default 2). A request held high is therefore accepted once every `XFER_CYC` cycles, with the stall output high in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| xreq_n | input | 1 | Asynchronous bus request from the outside master, active low |
| excl_mode | input | 1 | Port reserved for core; DMA no longer blocks outside grants |
| core_req | input | 1 | Core access to external space pending, held until accepted |
| core_wr | input | 1 | Core access is a write (1) or read (0) |
| core_lock | input | 1 | Core read is the first of a locked read pair |
| dma_req | input | 1 | DMA access to external space pending, held until accepted |
| xgnt_n | output | 1 | Bus grant to the outside master, active low |
| held_off | output | 1 | An internal access is waiting because the bus is away |
| core_stall | output | 1 | Core access not accepted this cycle |
| dma_stall | output | 1 | DMA access not accepted this cycle |
| drv_en | output | 7 | Output driver enables of the port, bit order as in R3 |

## Verification
The case that is hardest to reach from the ports is a locked read pair with an outside request arriving in the gap between the two reads. The bench gets there by issuing one locked read and then dropping the core request. It then asserts `xreq_n` and keeps the core idle for many cycles while checking that no grant appears, before sending the second read. Stall and resume ordering is reached in a similar way. The bench holds a core request through a full grant and counts the edges from the release of the request to the acceptance, sweeping the offset at which the request first arrived.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

    typedef enum logic [1:0] {
        ST_OWN   = 2'd0,
        ST_HAND  = 2'd1,
        ST_GRANT = 2'd2,
        ST_BACK  = 2'd3
    } xbh_state_e;

    typedef struct packed {
        logic wr_strobe;
        logic rd_strobe;
        logic io_sel;
        logic boot_sel;
        logic mem_sel;
        logic data;
        logic addr;
    } xbh_drv_s;

    localparam int DRV_W = $bits(xbh_drv_s);

    function automatic xbh_drv_s drv_all(input logic on);
        xbh_drv_s d;
        d.wr_strobe = on;
        d.rd_strobe = on;
        d.io_sel    = on;
        d.boot_sel  = on;
        d.mem_sel   = on;
        d.data      = on;
        d.addr      = on;
        return d;
    endfunction

    function automatic logic owns_port(input xbh_state_e st);
        return st == ST_OWN;
    endfunction

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= ~async_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign req = chain[N-1];
endmodule

// File: rtl/xbh_xfer_track.sv
module xbh_xfer_track #(
    parameter int XFER_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic core_go,
    input  logic core_wr,
    input  logic core_lock,
    input  logic dma_go,
    output logic busy,
    output logic lock_pend
);
    localparam int CYC   = (XFER_CYC < 1) ? 1 : XFER_CYC;
    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (core_go || dma_go) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_pend <= 1'b0;
        end else if (core_go) begin
            lock_pend <= core_lock & ~core_wr;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/xbh_ctrl.sv
module xbh_ctrl
    import xbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_sync,
    input  logic       core_req,
    input  logic       dma_req,
    input  logic       excl_mode,
    input  logic       busy,
    input  logic       lock_pend,
    output xbh_state_e state,
    output logic       core_go,
    output logic       dma_go
);
    logic own;
    logic dma_blocks;
    logic grant_start;
    xbh_state_e nxt;

    assign own         = owns_port(state);
    assign dma_blocks  = dma_req & ~excl_mode;
    assign grant_start = own & req_sync & ~busy & ~lock_pend
                         & ~core_req & ~dma_blocks;
    assign core_go     = own & ~busy & core_req;
    assign dma_go      = own & ~busy & ~core_req & dma_req & ~grant_start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWN:   if (grant_start) nxt = ST_HAND;
            ST_HAND:  nxt = ST_GRANT;
            ST_GRANT: if (!req_sync) nxt = ST_BACK;
            ST_BACK:  nxt = ST_OWN;
            default:  nxt = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OWN;
        else     state <= nxt;
    end
endmodule

// File: rtl/xbus_handoff.sv
module xbus_handoff
    import xbh_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int XFER_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xreq_n,
    input  logic             excl_mode,
    input  logic             core_req,
    input  logic             core_wr,
    input  logic             core_lock,
    input  logic             dma_req,
    output logic             xgnt_n,
    output logic             held_off,
    output logic             core_stall,
    output logic             dma_stall,
    output logic [DRV_W-1:0] drv_en
);
    logic       req_sync;
    logic       busy;
    logic       lock_pend;
    logic       core_go;
    logic       dma_go;
    xbh_state_e state;
    xbh_drv_s   drv;

    xbh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (xreq_n),
        .req     (req_sync)
    );

    xbh_xfer_track #(.XFER_CYC(XFER_CYC)) u_track (
        .clk       (clk),
        .rst       (rst),
        .core_go   (core_go),
        .core_wr   (core_wr),
        .core_lock (core_lock),
        .dma_go    (dma_go),
        .busy      (busy),
        .lock_pend (lock_pend)
    );

    xbh_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_sync  (req_sync),
        .core_req  (core_req),
        .dma_req   (dma_req),
        .excl_mode (excl_mode),
        .busy      (busy),
        .lock_pend (lock_pend),
        .state     (state),
        .core_go   (core_go),
        .dma_go    (dma_go)
    );

    assign drv        = drv_all(owns_port(state));
    assign drv_en     = drv;
    assign xgnt_n     = (state != ST_GRANT);
    assign held_off   = (core_req | dma_req) & ~owns_port(state);
    assign core_stall = core_req & ~core_go;
    assign dma_stall  = dma_req & ~dma_go;
endmodule

// File: rtl/xbh_checker.sv
module xbh_checker (
    input logic       clk,
    input logic       rst,
    input logic       xgnt_n,
    input logic       core_req,
    input logic       core_stall,
    input logic       held_off,
    input logic [6:0] drv_en,
    input logic       req_sync,
    input logic       lock_pend
);
    // R3: no driver enabled while the outside master holds the bus
    a_r3_drivers_off: assert property (@(posedge clk) disable iff (rst)
        !xgnt_n |-> drv_en == 7'd0);

    // R7: drivers already off in the cycle before the grant
    a_r7_off_before: assert property (@(posedge clk) disable iff (rst)
        $fell(xgnt_n) |-> $past(drv_en) == 7'd0);

    // R7: drivers come back one cycle after the grant is removed
    a_r7_on_after: assert property (@(posedge clk) disable iff (rst)
        $rose(xgnt_n) |=> drv_en == 7'h7f);

    // R2: synchronized request was already present two cycles before the grant
    a_r2_min_latency: assert property (@(posedge clk) disable iff (rst)
        $fell(xgnt_n) |-> $past(req_sync, 2));

    // R1: no grant start while the core was asking
    a_r1_core_first: assert property (@(posedge clk) disable iff (rst)
        $fell(xgnt_n) |-> !$past(core_req, 2));

    // R5: no grant start inside a locked read pair
    a_r5_lock_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(xgnt_n) |-> !$past(lock_pend, 2));

    // R4 / R8: a core access during a grant is stalled and flagged
    a_r4_stall_granted: assert property (@(posedge clk) disable iff (rst)
        (!xgnt_n && core_req) |-> (core_stall && held_off));
endmodule

bind xbus_handoff xbh_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .xgnt_n     (xgnt_n),
    .core_req   (core_req),
    .core_stall (core_stall),
    .held_off   (held_off),
    .drv_en     (drv_en),
    .req_sync   (req_sync),
    .lock_pend  (lock_pend)
);

// File: tb/xbus_handoff_bench.sv
module xbus_handoff_bench;
    localparam int XFER = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xreq_n = 1'b1, excl_mode = 1'b0;
    logic core_req = 1'b0, core_wr = 1'b0, core_lock = 1'b0, dma_req = 1'b0;
    logic xgnt_n, held_off, core_stall, dma_stall;
    logic [6:0] drv_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xbus_handoff #(.SYNC_STAGES(2), .XFER_CYC(XFER)) u_xbus_handoff (
        .clk(clk), .rst(rst), .xreq_n(xreq_n), .excl_mode(excl_mode),
        .core_req(core_req), .core_wr(core_wr), .core_lock(core_lock),
        .dma_req(dma_req), .xgnt_n(xgnt_n), .held_off(held_off),
        .core_stall(core_stall), .dma_stall(dma_stall), .drv_en(drv_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // count edges until xgnt_n reaches the given level (limit 40)
    task automatic edges_to_gnt(input logic lvl, output int n);
        n = 0;
        while (xgnt_n !== lvl && n < 40) begin
            step();
            n++;
        end
    endtask

    task automatic settle();
        repeat (6) step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step();

        // reset state
        chk("R3 reset gnt", int'(xgnt_n), 1);
        chk("R3 reset drv", int'(drv_en), 127);
        chk("R8 reset held", int'(held_off), 0);
        chk("R4 reset stall", int'(core_stall) + int'(dma_stall), 0);

        // R2 / R3 / R6 / R7: latency sweep over idle offsets
        for (int off = 0; off < 4; off++) begin
            repeat (off) step();
            xreq_n = 1'b0;
            n = 0;
            while (xgnt_n !== 1'b0 && n < 40) begin
                if (n == 3) chk("R7 off before grant", int'(drv_en), 0);
                step();
                n++;
            end
            chk("R2 grant latency", n, 4);
            chk("R3 drivers off", int'(drv_en), 0);
            repeat (off + 2) begin
                step();
                chk("R3 grant held", int'(xgnt_n), 0);
            end
            xreq_n = 1'b1;
            edges_to_gnt(1'b1, n);
            chk("R6 release latency", n, 3);
            chk("R7 still off at release", int'(drv_en), 0);
            step();
            chk("R7 back on", int'(drv_en), 127);
            settle();
        end

        // R1: core request held continuously blocks the grant
        core_req = 1'b1;
        xreq_n = 1'b0;
        repeat (12) begin
            step();
            chk("R1 core blocks", int'(xgnt_n), 1);
        end
        core_req = 1'b0;
        edges_to_gnt(1'b0, n);
        chk("R1 grant after core idle", int'(n <= 6), 1);
        xreq_n = 1'b1;
        edges_to_gnt(1'b1, n);
        settle();

        // R1 / R9: DMA blocks in normal mode, not in exclusive mode
        dma_req = 1'b1;
        xreq_n = 1'b0;
        repeat (12) begin
            step();
            chk("R1 dma blocks", int'(xgnt_n), 1);
        end
        excl_mode = 1'b1;
        edges_to_gnt(1'b0, n);
        chk("R9 grant in exclusive", int'(n <= 6), 1);
        chk("R4 dma stalled", int'(dma_stall), 1);
        chk("R8 held by dma", int'(held_off), 1);
        xreq_n = 1'b1;
        edges_to_gnt(1'b1, n);
        step();
        chk("R4 dma resumes", int'(dma_stall), 0);
        dma_req = 1'b0;
        excl_mode = 1'b0;
        settle();

        // R4 / R6 / R8: stall and resume, swept over grant length
        for (int len = 1; len < 4; len++) begin
            xreq_n = 1'b0;
            edges_to_gnt(1'b0, n);
            chk("R8 held idle", int'(held_off), 0);
            core_req = 1'b1;
            core_wr = len[0];
            #1;
            chk("R4 core stalled", int'(core_stall), 1);
            chk("R8 held set", int'(held_off), 1);
            repeat (len) step();
            xreq_n = 1'b1;
            n = 0;
            while (core_stall === 1'b1 && n < 40) begin
                step();
                n++;
            end
            chk("R6 resume latency", n, 4);
            chk("R4 drivers on at accept", int'(drv_en), 127);
            chk("R8 held clear", int'(held_off), 0);
            step();
            core_req = 1'b0;
            settle();
        end

        // R10: accept cadence of a continuously held request
        core_req = 1'b1;
        core_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R10 cadence", int'(core_stall), int'((i % XFER) != 0));
            step();
        end
        core_req = 1'b0;
        settle();

        // R5: locked read pair holds off the grant in its gap
        core_req = 1'b1;
        core_lock = 1'b1;
        chk("R5 first read accepted", int'(core_stall), 0);
        step();
        core_req = 1'b0;
        core_lock = 1'b0;
        xreq_n = 1'b0;
        repeat (15) begin
            step();
            chk("R5 no grant in pair", int'(xgnt_n), 1);
        end
        core_req = 1'b1;
        chk("R5 second read accepted", int'(core_stall), 0);
        step();
        core_req = 1'b0;
        edges_to_gnt(1'b0, n);
        chk("R5 grant after pair", int'(n <= 6), 1);
        xreq_n = 1'b1;
        edges_to_gnt(1'b1, n);
        settle();

        // R5: unlocked read then idle lets grant in before the write
        core_req = 1'b1;
        step();
        core_req = 1'b0;
        xreq_n = 1'b0;
        edges_to_gnt(1'b0, n);
        chk("R5 read-write gap grant", int'(xgnt_n), 0);
        core_req = 1'b1;
        core_wr = 1'b1;
        #1;
        chk("R4 write stalled", int'(core_stall), 1);
        xreq_n = 1'b1;
        n = 0;
        while (core_stall === 1'b1 && n < 40) begin
            step();
            n++;
        end
        chk("R6 write resumes", n, 4);
        step();
        core_req = 1'b0;
        core_wr = 1'b0;
        settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule